// File: doc/BRIEF.md
# Vector Lane Mask and Accumulate Unit

This unit sits just ahead of the write into vector memory. It takes one unpacked vector of four 32-bit lanes (x, y, z, w) per clock. For each lane it chooses what goes out: the incoming data, the lane's entry in a persistent row register, a column word picked by the write-cycle index, or nothing at all, in which case the lane is write-protected. A 32-bit mask word supplies the per-lane choices. It holds one 8-bit sub-mask for each write cycle, and the unit uses the sub-mask whose index is the cycle count saturated at 3.

An accumulate mode can act on the data lanes. It can add the row register to the data, add and then store the sums back into the row register, or copy the data into the row register unchanged. The format used for 4-bit-per-component data has no accumulate mode, so a flag from the unpacker turns the mode off for it. The row and column registers are loaded through a one-word load port.

The write data and per-lane enables leave through a registered valid/ready stage. The row register state is visible on an output at all times.

Top module: `vlane_maskmode`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every row-register lane and column word is 0.
- R2: The unit takes sub-mask byte k = min(`in_cyc`, 3) from `mask_word[8k+7:8k]`. Lane i uses bits [2i+1:2i] of that byte, with lane x as i=0 and bits [31:0] of the data. When `mask_en` is 0, every lane uses code 0 and `mask_word` has no effect.
- R3: Code 0 writes the data-path value. Code 1 writes that lane's row entry. Code 2 writes column word k to every lane that has this code. Code 3 clears that lane's bit in `out_wen` and drives the lane's data to 0. Lanes with codes 0, 1 and 2 have their `out_wen` bit set.
- R4: Any `in_cyc` value of 3 or more selects sub-mask byte 3 and column word 3.
- R5: `acc_mode` 1 writes data plus row entry, modulo 2^32, on code-0 lanes and leaves the row register unchanged.
- R6: `acc_mode` 2 writes data plus row entry on code-0 lanes and stores the same sums into those row lanes. The other row lanes keep their values.
- R7: `acc_mode` 3 writes the data unchanged and copies it into the row lanes of code-0 lanes.
- R8: `acc_mode` 0 never changes the row register. When `nibble_fmt` is 1, the unit behaves as if `acc_mode` were 0.
- R9: If masking is on and the selected sub-mask is 0xFF, the vector is consumed with no output beat and no row-register change.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output beat holds unchanged. With `out_ready` held at 1, one vector is taken on every clock.
- R11: When `ld_en` is 1, `ld_val` is written on the next edge, to column word `ld_idx` if `ld_col` is 1 and to row lane `ld_idx` otherwise. A load to a row lane wins over an accumulate update of the same lane on the same edge.
- R12: A row-register update made by one vector is used by the vector taken on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Unit can take a vector this clock |
| in_data | input | 128 | Unpacked vector, lane x in [31:0] |
| in_cyc | input | 8 | Write-cycle counter for this vector |
| mask_word | input | 32 | Four 8-bit per-cycle sub-masks |
| mask_en | input | 1 | Apply the lane codes |
| acc_mode | input | 2 | 0 off, 1 add, 2 add and store, 3 copy to row |
| nibble_fmt | input | 1 | 4-bit format in use; turns off accumulate |
| ld_en | input | 1 | Load one row lane or column word |
| ld_col | input | 1 | 1 targets a column word, 0 a row lane |
| ld_idx | input | 2 | Lane or column index for the load |
| ld_val | input | 32 | Load value |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 128 | Write data, lane x in [31:0] |
| out_wen | output | 4 | Per-lane write enables, bit i for lane i |
| row_state | output | 128 | Current row register, lane x in [31:0] |

## Verification
An accepted vector shows up on `out_data` and `out_wen` one edge after acceptance, and its row-register effect shows up on `row_state` at that same edge. A load through the load port appears on `row_state` one edge after it is driven. The bench drives every input just after a falling edge and reads results at the next falling edge, which is exactly one rising edge later. A back-to-back pair checks that the second vector saw the first one's row update. A stall holds `out_ready` low across several edges and compares the beat before and after the stall. For an all-protected vector, the bench checks that `out_valid` stays low and that `row_state` is unchanged.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_ROW  = 2'd1,
    SRC_COL  = 2'd2,
    SRC_HOLD = 2'd3
  } lane_src_e;

  typedef enum logic [1:0] {
    ACC_NONE     = 2'd0,
    ACC_ADD      = 2'd1,
    ACC_ADD_KEEP = 2'd2,
    ACC_COPY     = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/vmm_rst_sync.sv
module vmm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vmm_submask_pick.sv
module vmm_submask_pick #(
  parameter int LANES   = 4,
  parameter int NUM_CYC = 4,
  parameter int CYC_W   = 8
) (
  input  logic [2*LANES*NUM_CYC-1:0] mask_word,
  input  logic                       mask_en,
  input  logic [CYC_W-1:0]           cyc,
  output logic [2*LANES-1:0]         lane_codes,
  output logic [$clog2(NUM_CYC)-1:0] cyc_idx,
  output logic                       all_hold
);
  localparam int SUB_W  = 2 * LANES;
  localparam int CIDX_W = $clog2(NUM_CYC);
  localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(NUM_CYC - 1);

  logic [CYC_W-1:0] cyc_sat;
  logic [SUB_W-1:0] sub;

  always_comb begin
    cyc_sat    = (cyc >= CYC_TOP) ? CYC_TOP : cyc;
    cyc_idx    = cyc_sat[CIDX_W-1:0];
    sub        = mask_word[cyc_idx*SUB_W +: SUB_W];
    all_hold   = mask_en && (&sub);
    lane_codes = mask_en ? sub : '0;
  end
endmodule

// File: rtl/vmm_lane.sv
module vmm_lane
  import vmm_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  lane_src_e         src,
  input  acc_mode_e         mode,
  input  logic [LANE_W-1:0] data,
  input  logic [LANE_W-1:0] row,
  input  logic [LANE_W-1:0] col,
  output logic              wr_en,
  output logic [LANE_W-1:0] wr_val,
  output logic              row_upd,
  output logic [LANE_W-1:0] row_val
);
  logic [LANE_W-1:0] sum;

  always_comb begin
    sum     = data + row;
    wr_en   = 1'b1;
    wr_val  = data;
    row_upd = 1'b0;
    row_val = data;
    unique case (src)
      SRC_DATA: begin
        if ((mode == ACC_ADD) || (mode == ACC_ADD_KEEP)) wr_val = sum;
        row_upd = (mode == ACC_ADD_KEEP) || (mode == ACC_COPY);
        row_val = (mode == ACC_ADD_KEEP) ? sum : data;
      end
      SRC_ROW:  wr_val = row;
      SRC_COL:  wr_val = col;
      SRC_HOLD: begin
        wr_en  = 1'b0;
        wr_val = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vmm_rowcol_store.sv
module vmm_rowcol_store #(
  parameter int LANES   = 4,
  parameter int NUM_CYC = 4,
  parameter int LANE_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic                          ld_col,
  input  logic [IDX_W-1:0]              ld_idx,
  input  logic [LANE_W-1:0]             ld_val,
  input  logic                          upd_en,
  input  logic [LANES-1:0]              upd_mask,
  input  logic [LANES-1:0][LANE_W-1:0]  upd_val,
  output logic [LANES-1:0][LANE_W-1:0]  row_q,
  output logic [NUM_CYC-1:0][LANE_W-1:0] col_q
);
  for (genvar i = 0; i < LANES; i++) begin : g_row
    logic              ld_hit;
    logic              row_ce;
    logic [LANE_W-1:0] row_nxt;

    always_comb begin
      ld_hit  = ld_en && !ld_col && (ld_idx == IDX_W'(i));
      row_ce  = ld_hit || (upd_en && upd_mask[i]);
      row_nxt = ld_hit ? ld_val : upd_val[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[i] <= '0;
      else if (row_ce) row_q[i] <= row_nxt;
    end
  end

  for (genvar n = 0; n < NUM_CYC; n++) begin : g_col
    logic col_ce;

    always_comb col_ce = ld_en && ld_col && (ld_idx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q[n] <= '0;
      else if (col_ce) col_q[n] <= ld_val;
    end
  end
endmodule

// File: rtl/vlane_maskmode.sv
module vlane_maskmode
  import vmm_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int NUM_CYC = 4,
  parameter int LANE_W  = 32,
  parameter int CYC_W   = 8
) (
  input  logic                                                 clk,
  input  logic                                                 rst_n,
  input  logic                                                 in_valid,
  output logic                                                 in_ready,
  input  logic [LANES*LANE_W-1:0]                              in_data,
  input  logic [CYC_W-1:0]                                     in_cyc,
  input  logic [2*LANES*NUM_CYC-1:0]                           mask_word,
  input  logic                                                 mask_en,
  input  logic [1:0]                                           acc_mode,
  input  logic                                                 nibble_fmt,
  input  logic                                                 ld_en,
  input  logic                                                 ld_col,
  input  logic [$clog2((LANES > NUM_CYC) ? LANES : NUM_CYC)-1:0] ld_idx,
  input  logic [LANE_W-1:0]                                    ld_val,
  output logic                                                 out_valid,
  input  logic                                                 out_ready,
  output logic [LANES*LANE_W-1:0]                              out_data,
  output logic [LANES-1:0]                                     out_wen,
  output logic [LANES*LANE_W-1:0]                              row_state
);
  localparam int IDX_W  = $clog2((LANES > NUM_CYC) ? LANES : NUM_CYC);
  localparam int CIDX_W = $clog2(NUM_CYC);

  logic                          rst_n_s;
  logic [2*LANES-1:0]            lane_codes;
  logic [CIDX_W-1:0]             cyc_idx;
  logic                          all_hold;
  acc_mode_e                     mode_eff;
  logic                          accept;
  logic                          commit;

  logic [LANES-1:0][LANE_W-1:0]   data_v;
  logic [LANES-1:0][LANE_W-1:0]   row_q;
  logic [NUM_CYC-1:0][LANE_W-1:0] col_q;
  logic [LANES-1:0][LANE_W-1:0]   wr_val;
  logic [LANES-1:0]               wr_en;
  logic [LANES-1:0]               row_upd;
  logic [LANES-1:0][LANE_W-1:0]   row_val;

  logic                          ov_q, ov_nxt;
  logic [LANES*LANE_W-1:0]       od_q, od_nxt;
  logic [LANES-1:0]              ow_q, ow_nxt;
  logic                          o_ce;

  vmm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vmm_submask_pick #(
    .LANES   (LANES),
    .NUM_CYC (NUM_CYC),
    .CYC_W   (CYC_W)
  ) u_pick (
    .mask_word  (mask_word),
    .mask_en    (mask_en),
    .cyc        (in_cyc),
    .lane_codes (lane_codes),
    .cyc_idx    (cyc_idx),
    .all_hold   (all_hold)
  );

  always_comb begin
    data_v   = in_data;
    mode_eff = nibble_fmt ? ACC_NONE : acc_mode_e'(acc_mode);
    in_ready = !ov_q || out_ready;
    accept   = in_valid && in_ready;
    commit   = accept && !all_hold;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vmm_lane #(.LANE_W(LANE_W)) u_lane (
      .src     (lane_src_e'(lane_codes[2*i +: 2])),
      .mode    (mode_eff),
      .data    (data_v[i]),
      .row     (row_q[i]),
      .col     (col_q[cyc_idx]),
      .wr_en   (wr_en[i]),
      .wr_val  (wr_val[i]),
      .row_upd (row_upd[i]),
      .row_val (row_val[i])
    );
  end

  vmm_rowcol_store #(
    .LANES   (LANES),
    .NUM_CYC (NUM_CYC),
    .LANE_W  (LANE_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ld_en    (ld_en),
    .ld_col   (ld_col),
    .ld_idx   (ld_idx),
    .ld_val   (ld_val),
    .upd_en   (commit),
    .upd_mask (row_upd),
    .upd_val  (row_val),
    .row_q    (row_q),
    .col_q    (col_q)
  );

  // Output stage: next state
  always_comb begin
    o_ce   = commit;
    od_nxt = wr_val;
    ow_nxt = wr_en;
    if (accept) ov_nxt = !all_hold;
    else        ov_nxt = ov_q && !out_ready;
  end

  // Output stage: registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ov_q <= 1'b0;
    else          ov_q <= ov_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      od_q <= '0;
      ow_q <= '0;
    end else if (o_ce) begin
      od_q <= od_nxt;
      ow_q <= ow_nxt;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_wen   = ow_q;
  assign row_state = row_q;
endmodule

// File: rtl/vmm_chk.sv
module vmm_chk #(
  parameter int LANES   = 4,
  parameter int NUM_CYC = 4,
  parameter int LANE_W  = 32,
  parameter int CYC_W   = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [LANES*LANE_W-1:0]       in_data,
  input logic [CYC_W-1:0]              in_cyc,
  input logic [2*LANES*NUM_CYC-1:0]    mask_word,
  input logic                          mask_en,
  input logic [1:0]                    acc_mode,
  input logic                          nibble_fmt,
  input logic                          ld_en,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [LANES*LANE_W-1:0]       out_data,
  input logic [LANES-1:0]              out_wen,
  input logic [LANES*LANE_W-1:0]       row_state
);
  localparam int SUB_W = 2 * LANES;
  localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(NUM_CYC - 1);

  logic [CYC_W-1:0] cs;
  logic [SUB_W-1:0] sub_c;
  logic             acc;
  logic             full_hold;

  always_comb begin
    cs        = (in_cyc >= CYC_TOP) ? CYC_TOP : in_cyc;
    sub_c     = mask_word[cs*SUB_W +: SUB_W];
    acc       = in_valid && in_ready;
    full_hold = mask_en && (&sub_c);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_hold
    a_r3_hold_lane_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mask_en && !full_hold && (sub_c[2*i +: 2] == 2'd3)) |=> (out_valid && !out_wen[i]));
  end

  a_r9_all_hold_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && full_hold) |=> !out_valid);

  a_r10_stall_holds_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_wen)));

  a_r10_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_row_still_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && (!acc || full_hold || nibble_fmt || (acc_mode == 2'd0))) |=> $stable(row_state));

  a_r7_copy_into_row: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ld_en && !nibble_fmt && (acc_mode == 2'd3) && !full_hold &&
     (!mask_en || (sub_c[1:0] == 2'd0)))
    |=> (row_state[LANE_W-1:0] == $past(in_data[LANE_W-1:0])));
endmodule

bind vlane_maskmode vmm_chk #(
  .LANES   (LANES),
  .NUM_CYC (NUM_CYC),
  .LANE_W  (LANE_W),
  .CYC_W   (CYC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_cyc     (in_cyc),
  .mask_word  (mask_word),
  .mask_en    (mask_en),
  .acc_mode   (acc_mode),
  .nibble_fmt (nibble_fmt),
  .ld_en      (ld_en),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_wen    (out_wen),
  .row_state  (row_state)
);

// File: tb/vlane_maskmode_tb.sv
module vlane_maskmode_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready;
  logic [127:0] in_data;
  logic [7:0]   in_cyc;
  logic [31:0]  mask_word;
  logic         mask_en;
  logic [1:0]   acc_mode;
  logic         nibble_fmt;
  logic         ld_en, ld_col;
  logic [1:0]   ld_idx;
  logic [31:0]  ld_val;
  logic         out_valid, out_ready;
  logic [127:0] out_data;
  logic [3:0]   out_wen;
  logic [127:0] row_state;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vlane_maskmode u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_cyc(in_cyc), .mask_word(mask_word), .mask_en(mask_en),
    .acc_mode(acc_mode), .nibble_fmt(nibble_fmt), .ld_en(ld_en), .ld_col(ld_col),
    .ld_idx(ld_idx), .ld_val(ld_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_wen(out_wen), .row_state(row_state)
  );

  function automatic logic [127:0] v4(input logic [31:0] w, z, y, x);
    return {w, z, y, x};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_data = '0; in_cyc = '0; mask_word = '0; mask_en = 0;
    acc_mode = 0; nibble_fmt = 0; ld_en = 0; ld_col = 0; ld_idx = 0; ld_val = '0;
  endtask

  // Drive one vector after a falling edge; return at the next falling edge
  task automatic send(input logic [127:0] d, input logic [31:0] m, input logic en,
                      input logic [1:0] md, input logic nib, input logic [7:0] cy);
    in_data = d; mask_word = m; mask_en = en; acc_mode = md; nibble_fmt = nib;
    in_cyc = cy; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic load(input logic col, input logic [1:0] idx, input logic [31:0] val);
    ld_en = 1; ld_col = col; ld_idx = idx; ld_val = val;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 in_ready", {127'd0, in_ready}, 128'd1);
    chk("R1 row_state", row_state, 128'd0);
    send(v4(1, 2, 3, 4), 32'hAAAA_AAAA, 1, 0, 0, 0);
    chk("R1 column words zero", out_data, 128'd0);
    @(negedge clk);
  endtask

  task automatic t_load();
    for (int i = 0; i < 4; i++) load(0, 2'(i), 32'h100 + i);
    for (int n = 0; n < 4; n++) load(1, 2'(n), 32'hC000_0000 + n);
    chk("R11 row load", row_state, v4(32'h103, 32'h102, 32'h101, 32'h100));
  endtask

  task automatic t_pass();
    send(v4(32'hD3, 32'hD2, 32'hD1, 32'hD0), 32'hFFFF_FFFF, 0, 0, 0, 2);
    chk("R2 mask off data", out_data, v4(32'hD3, 32'hD2, 32'hD1, 32'hD0));
    chk("R2 mask off wen", {124'd0, out_wen}, 128'hF);
    chk("R2 out_valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
  endtask

  task automatic t_codes();
    // byte1 = 0xE4: x data, y row, z column, w protect
    send(v4(32'hA3, 32'hA2, 32'hA1, 32'hA0), 32'h1B1B_E4FF, 1, 0, 0, 1);
    chk("R3 lane sources", out_data, v4(32'h0, 32'hC000_0001, 32'h101, 32'hA0));
    chk("R3 protect wen", {124'd0, out_wen}, 128'h7);
    @(negedge clk);
  endtask

  task automatic t_sat();
    send(v4(1, 2, 3, 4), 32'hAA00_0000, 1, 0, 0, 9);
    chk("R4 saturated column", out_data,
        v4(32'hC000_0003, 32'hC000_0003, 32'hC000_0003, 32'hC000_0003));
    chk("R4 saturated wen", {124'd0, out_wen}, 128'hF);
    @(negedge clk);
  endtask

  task automatic t_mode1();
    send(v4(9, 7, 5, 32'hFFFF_FFFF), 32'h0000_0040, 1, 1, 0, 0);
    chk("R5 add with wrap", out_data, v4(32'h103, 32'h109, 32'h106, 32'hFF));
    chk("R5 row unchanged", row_state, v4(32'h103, 32'h102, 32'h101, 32'h100));
    @(negedge clk);
  endtask

  task automatic t_mode2();
    send(v4(32'h1234, 3, 2, 1), 32'h0000_00C0, 1, 2, 0, 0);
    chk("R6 add output", out_data, v4(32'h0, 32'h105, 32'h103, 32'h101));
    chk("R6 wen", {124'd0, out_wen}, 128'h7);
    chk("R6 row stored", row_state, v4(32'h103, 32'h105, 32'h103, 32'h101));
    @(negedge clk);
  endtask

  task automatic t_mode3();
    send(v4(32'hAAAA, 32'hBBBB, 32'hCCCC, 32'hDDDD), 32'h0000_0004, 1, 3, 0, 0);
    chk("R7 copy output", out_data, v4(32'hAAAA, 32'hBBBB, 32'h103, 32'hDDDD));
    chk("R7 row copied", row_state, v4(32'hAAAA, 32'hBBBB, 32'h103, 32'hDDDD));
    @(negedge clk);
  endtask

  task automatic t_nibble();
    send(v4(4, 3, 2, 1), 32'h0, 0, 2, 1, 0);
    chk("R8 nibble forces mode 0", out_data, v4(4, 3, 2, 1));
    chk("R8 nibble row unchanged", row_state, v4(32'hAAAA, 32'hBBBB, 32'h103, 32'hDDDD));
    send(v4(8, 7, 6, 5), 32'h0, 0, 0, 0, 0);
    chk("R8 mode 0 row unchanged", row_state, v4(32'hAAAA, 32'hBBBB, 32'h103, 32'hDDDD));
    @(negedge clk);
  endtask

  task automatic t_allhold();
    send(v4(5, 6, 7, 8), 32'h00FF_0000, 1, 3, 0, 2);
    chk("R9 no beat", {127'd0, out_valid}, 128'd0);
    chk("R9 row unchanged", row_state, v4(32'hAAAA, 32'hBBBB, 32'h103, 32'hDDDD));
  endtask

  task automatic t_backtoback();
    logic [127:0] r0, ea, eb;
    r0 = row_state;
    for (int i = 0; i < 4; i++) begin
      ea[32*i +: 32] = r0[32*i +: 32] + 32'd1;
      eb[32*i +: 32] = r0[32*i +: 32] + 32'd3;
    end
    in_data = v4(1, 1, 1, 1); mask_en = 0; acc_mode = 2; nibble_fmt = 0; in_valid = 1;
    @(negedge clk);
    chk("R12 first sum", out_data, ea);
    in_data = v4(2, 2, 2, 2);
    @(negedge clk);
    in_valid = 0;
    chk("R12 second uses update", out_data, eb);
    chk("R10 one per clock", {127'd0, out_valid}, 128'd1);
    chk("R12 row after pair", row_state, eb);
    @(negedge clk);
  endtask

  task automatic t_stall();
    out_ready = 0;
    send(v4(11, 12, 13, 14), 32'h0, 0, 0, 0, 0);
    in_data = v4(21, 22, 23, 24); in_valid = 1;
    chk("R10 ready low in stall", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 beat held", out_data, v4(11, 12, 13, 14));
    chk("R10 valid held", {127'd0, out_valid}, 128'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 next beat after release", out_data, v4(21, 22, 23, 24));
    @(negedge clk);
    chk("R10 drained", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_ldpri();
    ld_en = 1; ld_col = 0; ld_idx = 0; ld_val = 32'h5555;
    send(v4(32'h44, 32'h33, 32'h22, 32'h11), 32'h0, 0, 3, 0, 0);
    ld_en = 0;
    chk("R11 load wins on lane", row_state, v4(32'h44, 32'h33, 32'h22, 32'h5555));
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    out_ready = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_pass();
    t_codes();
    t_sat();
    t_mode1();
    t_mode2();
    t_mode3();
    t_nibble();
    t_allhold();
    t_backtoback();
    t_stall();
    t_ldpri();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule